// File: doc/BRIEF.md
# Predicated Tree Reduction Engine

This block folds a vector of up to `MAX_VL` elements into one value. On a start pulse it captures the element array, an active length and a per-element enable mask into a private working bank. It then pairs slots over a series of passes. In each pass the pairing distance doubles, and each slot takes its partner's contribution, so the final value always ends up in slot 0.

A working enable bit travels through the tree together with the data. When a slot has no valid content and its partner does, the slot copies the partner instead of combining with it, so disabled elements never reach the result. The engine performs one pairing per clock. When it finishes, it raises a one-cycle done strobe together with the result and a flag that reports whether any element took part. Callers pick the operation with a 3-bit code. To run the reduction again, they simply issue another start.

Top module: `tree_reduce_engine`

## Requirements
- R1: After reset `result_o` is 0, `any_o` is 0, `done_o` is 0 and the engine is idle, ready to accept a start.
- R2: `op_i` selects the combine on `DW`-bit unsigned values: 0 adds modulo 2^DW, 1 takes the minimum, 2 takes the maximum, 3 is bitwise OR, 4 is bitwise AND. For codes 0 to 4 the result equals a left-to-right fold over the enabled elements in index order.
- R3: Element k (bit k of `pred_i`, bits `k*DW +: DW` of `elems_i`) contributes only if its enable bit is 1 and k < VL. Inputs are captured in the start cycle, so later changes to them have no effect on the result.
- R4: `any_o` is 1 exactly when VL is nonzero and at least one element with index below VL is enabled. When `any_o` is 0, `result_o` is 0.
- R5: A `vl_i` larger than `MAX_VL` is treated as `MAX_VL`.
- R6: `done_o` is high for exactly one cycle. It rises V+1 clock edges after the edge that accepted the start. V is the sum, over half-distances h = 1, 2, 4, ... with h < N, of ceil(N / 2h), where N is the effective VL. With N = 0 or 1 the delay is therefore one edge.
- R7: `result_o` and `any_o` change only on the edge that raises `done_o`. They hold their values between reductions.
- R8: A start pulse that arrives while a reduction is running is ignored. The running reduction completes with its own inputs and latency.
- R9: For codes 5 to 7 the lower slot of every pair is kept. The result is therefore the lowest-indexed enabled element below VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_i | input | 3 | Combine selection code |
| vl_i | input | $clog2(MAX_VL+1) | Active vector length |
| pred_i | input | MAX_VL | Per-element enable mask |
| elems_i | input | MAX_VL*DW | Element array, element k at bits k*DW +: DW |
| result_o | output | DW | Reduced value, held until the next completion |
| any_o | output | 1 | At least one element took part |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the engine with `MAX_VL = 8` and `DW = 8`. This makes every one of the 256 enable masks reachable for each active length from 0 to 10, so both the clamping of lengths above 8 and every pattern of lone valid partners at every tree level are swept for all five combine codes. The reserved codes get a thinned sweep. Every run also checks the exact completion latency against the arithmetic pass count. Separate runs cover the hold behaviour of the outputs and a start pulse delivered during a busy reduction.

// File: rtl/tre_pkg.sv
package tre_pkg;
  typedef enum logic [2:0] {
    TRE_ADD = 3'd0,
    TRE_MIN = 3'd1,
    TRE_MAX = 3'd2,
    TRE_OR  = 3'd3,
    TRE_AND = 3'd4
  } tre_op_e;
endpackage

// File: rtl/tre_alu.sv
module tre_alu
  import tre_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          a_vld_i,
  input  logic          b_vld_i,
  output logic [DW-1:0] y_o,
  output logic          y_vld_o
);
  logic [DW-1:0] fn;

  always_comb begin
    case (op_i)
      TRE_ADD: fn = a_i + b_i;
      TRE_MIN: fn = (b_i < a_i) ? b_i : a_i;
      TRE_MAX: fn = (b_i > a_i) ? b_i : a_i;
      TRE_OR:  fn = a_i | b_i;
      TRE_AND: fn = a_i & b_i;
      default: fn = a_i;  // reserved codes keep the lower slot
    endcase
  end

  // lone valid partner is copied, not combined
  assign y_o     = (a_vld_i && b_vld_i) ? fn : (b_vld_i ? b_i : a_i);
  assign y_vld_o = a_vld_i | b_vld_i;
endmodule

// File: rtl/tre_sched.sv
module tre_sched #(
  parameter int MAX_VL = 16,
  parameter int VLW    = $clog2(MAX_VL + 1),
  parameter int CW     = $clog2(MAX_VL) + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  output logic           busy_o,
  output logic           load_o,
  output logic           step_o,
  output logic           fin_o,
  output logic [CW-1:0]  idx_o,
  output logic [CW-1:0]  partner_o,
  output logic [CW-1:0]  vl_o
);
  logic          busy_q;
  logic [CW-1:0] vl_q, half_q, idx_q, nxt_idx, vl_clamp;

  assign vl_clamp  = (CW'(vl_i) > CW'(MAX_VL)) ? CW'(MAX_VL) : CW'(vl_i);
  assign load_o    = start_i & ~busy_q;
  assign fin_o     = busy_q & (half_q >= vl_q);
  assign step_o    = busy_q & ~fin_o;
  assign nxt_idx   = idx_q + (half_q << 1);
  assign partner_o = idx_q + half_q;
  assign idx_o     = idx_q;
  assign vl_o      = vl_q;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      vl_q   <= '0;
      half_q <= CW'(1);
      idx_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      vl_q   <= vl_clamp;
      half_q <= CW'(1);
      idx_q  <= '0;
    end else if (fin_o) begin
      busy_q <= 1'b0;
    end else if (step_o) begin
      if (nxt_idx >= vl_q) begin
        half_q <= half_q << 1;
        idx_q  <= '0;
      end else begin
        idx_q <= nxt_idx;
      end
    end
  end

  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(vl_q));

  // R6
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (idx_q < vl_q) && (vl_q <= CW'(MAX_VL)));
endmodule

// File: rtl/tre_bank.sv
module tre_bank #(
  parameter int MAX_VL = 16,
  parameter int DW     = 32,
  parameter int IW     = $clog2(MAX_VL)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [MAX_VL*DW-1:0] elems_i,
  input  logic [MAX_VL-1:0]    pred_i,
  input  logic                 wr_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 wr_vld_i,
  input  logic [IW-1:0]        b_idx_i,
  output logic [DW-1:0]        a_d_o,
  output logic                 a_p_o,
  output logic [DW-1:0]        b_d_o,
  output logic                 b_p_o,
  output logic [DW-1:0]        s0_d_o,
  output logic                 s0_p_o
);
  logic [DW-1:0]     data_q [MAX_VL];
  logic [MAX_VL-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_VL; k++) data_q[k] <= '0;
      vld_q <= '0;
    end else if (load_i) begin
      for (int k = 0; k < MAX_VL; k++)
        data_q[k] <= pred_i[k] ? elems_i[k*DW +: DW] : '0;
      vld_q <= pred_i;
    end else if (wr_i) begin
      data_q[wr_idx_i] <= wr_data_i;
      vld_q[wr_idx_i]  <= wr_vld_i;
    end
  end

  assign a_d_o  = data_q[wr_idx_i];
  assign a_p_o  = vld_q[wr_idx_i];
  assign b_d_o  = data_q[b_idx_i];
  assign b_p_o  = vld_q[b_idx_i];
  assign s0_d_o = data_q[0];
  assign s0_p_o = vld_q[0];

  // R3
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !wr_i |=> $stable(s0_d_o) && $stable(s0_p_o));
endmodule

// File: rtl/tree_reduce_engine.sv
module tree_reduce_engine #(
  parameter int MAX_VL = 16,
  parameter int DW     = 32,
  localparam int VLW   = $clog2(MAX_VL + 1),
  localparam int IW    = $clog2(MAX_VL),
  localparam int CW    = IW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [2:0]           op_i,
  input  logic [VLW-1:0]       vl_i,
  input  logic [MAX_VL-1:0]    pred_i,
  input  logic [MAX_VL*DW-1:0] elems_i,
  output logic [DW-1:0]        result_o,
  output logic                 any_o,
  output logic                 done_o
);
  logic          busy, load, step, fin;
  logic [CW-1:0] idx, partner, vl_q;
  logic [2:0]    op_q;
  logic [DW-1:0] a_d, b_d, s0_d, y_d;
  logic          a_p, b_p, s0_p, y_p, b_ok, fin_ok;
  logic [DW-1:0] result_q;
  logic          any_q, done_q;

  tre_sched #(.MAX_VL(MAX_VL), .VLW(VLW), .CW(CW)) u_sched (
    .clk_i, .rst_ni, .start_i, .vl_i,
    .busy_o(busy), .load_o(load), .step_o(step), .fin_o(fin),
    .idx_o(idx), .partner_o(partner), .vl_o(vl_q)
  );

  tre_bank #(.MAX_VL(MAX_VL), .DW(DW), .IW(IW)) u_bank (
    .clk_i, .rst_ni, .load_i(load), .elems_i, .pred_i,
    .wr_i(step), .wr_idx_i(idx[IW-1:0]), .wr_data_i(y_d), .wr_vld_i(y_p),
    .b_idx_i(partner[IW-1:0]),
    .a_d_o(a_d), .a_p_o(a_p), .b_d_o(b_d), .b_p_o(b_p),
    .s0_d_o(s0_d), .s0_p_o(s0_p)
  );

  // partner beyond the active length never counts
  assign b_ok = (partner < vl_q) && b_p;

  tre_alu #(.DW(DW)) u_alu (
    .op_i(op_q), .a_i(a_d), .b_i(b_d), .a_vld_i(a_p), .b_vld_i(b_ok),
    .y_o(y_d), .y_vld_o(y_p)
  );

  assign fin_ok = (vl_q != '0) && s0_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= '0;
      result_q <= '0;
      any_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (load) op_q <= op_i;
      done_q <= fin;
      if (fin) begin
        any_q    <= fin_ok;
        result_q <= fin_ok ? s0_d : '0;
      end
    end
  end

  assign result_o = result_q;
  assign any_o    = any_q;
  assign done_o   = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  zero_when_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !any_o |-> result_o == '0);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin |=> $stable(result_o) && $stable(any_o));

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy || load);
endmodule

// File: tb/tree_reduce_engine_tb_top.sv
`timescale 1ns/1ps
module tree_reduce_engine_tb_top;
  localparam int MV  = 8;
  localparam int W   = 8;
  localparam int VLW = $clog2(MV + 1);

  logic              clk = 0, rst_n = 0, start = 0;
  logic [2:0]        op = 0;
  logic [VLW-1:0]    vl = 0;
  logic [MV-1:0]     pred = 0;
  logic [MV*W-1:0]   elems = 0;
  logic [W-1:0]      result;
  logic              any_f, done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tree_reduce_engine #(.MAX_VL(MV), .DW(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .vl_i(vl),
    .pred_i(pred), .elems_i(elems), .result_o(result), .any_o(any_f),
    .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MV*W-1:0] mk_data(input int seed);
    logic [MV*W-1:0] d;
    for (int k = 0; k < MV; k++) begin
      d[k*W +: W] = W'(seed * 53 + k * 29 + (seed >> 3) * k);
      if ((seed % 11) == 0 && k == 2) d[k*W +: W] = '0;
      if ((seed % 13) == 0 && k == 5) d[k*W +: W] = '1;
    end
    return d;
  endfunction

  // returns {any, value}: in-order fold over enabled elements
  function automatic logic [W:0] fold(input int o, input int n_in,
                                      input logic [MV-1:0] p, input logic [MV*W-1:0] d);
    int n = (n_in > MV) ? MV : n_in;
    logic have = 0;
    logic [W-1:0] acc = '0, e;
    for (int k = 0; k < n; k++) begin
      if (p[k]) begin
        e = d[k*W +: W];
        if (!have) begin acc = e; have = 1; end
        else case (o)
          0: acc = acc + e;
          1: acc = (e < acc) ? e : acc;
          2: acc = (e > acc) ? e : acc;
          3: acc = acc | e;
          4: acc = acc & e;
          default: acc = acc;
        endcase
      end
    end
    return {have, acc};
  endfunction

  function automatic int lat(input int n_in);
    int n = (n_in > MV) ? MV : n_in;
    int v = 0;
    for (int h = 1; h < n; h = h * 2) v += (n + 2*h - 1) / (2*h);
    return v + 1;
  endfunction

  task automatic run(input int o, input int n, input logic [MV-1:0] p,
                     input int seed, input bit interfere);
    logic [MV*W-1:0] d = mk_data(seed);
    logic [W:0] ex = fold(o, n, p, d);
    int cnt = 0;
    string rq;
    @(negedge clk);
    start = 1; op = 3'(o); vl = VLW'(n); pred = p; elems = d;
    @(negedge clk);
    start = 0; elems = ~d; pred = ~p; op = 3'(o + 1); vl = VLW'(n + 3);
    while (!done && cnt < 64) begin
      @(negedge clk);
      cnt++;
      if (interfere && cnt == 2) begin start = 1; elems = ~d; pred = '1; vl = VLW'(3); end
      if (interfere && cnt == 3) start = 0;
    end
    chk(interfere ? "R8 latency" : "R6 latency", cnt, lat(n));
    rq = interfere ? "R8 result" : (n > MV ? "R5 result" : (o > 4 ? "R9 result" : "R2 R3 result"));
    chk(rq, int'(result), int'(ex[W-1:0]));
    chk("R4 any", int'(any_f), int'(ex[W]));
    if (!ex[W]) chk("R4 zero", int'(result), 0);
    @(negedge clk);
    chk("R6 one-cycle done", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    int seed = 1;
    logic [W-1:0] r_hold;
    logic a_hold;
    repeat (3) @(negedge clk);
    chk("R1 result", int'(result), 0);
    chk("R1 any", int'(any_f), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done after release", int'(done), 0);

    // full sweep of masks for the five defined combines, VL 0..10
    for (int n = 0; n <= 10; n++)
      for (int p = 0; p < 256; p++)
        for (int o = 0; o < 5; o++) begin
          run(o, n, MV'(p), seed, 0);
          seed++;
        end

    // reserved codes keep the lower slot (R9)
    for (int o = 5; o < 8; o++)
      for (int n = 0; n <= 9; n++)
        for (int p = 0; p < 256; p += 17) begin
          run(o, n, MV'(p), seed, 0);
          seed++;
        end

    // R7: outputs hold between reductions
    run(0, 8, 8'hB5, 77, 0);
    r_hold = result; a_hold = any_f;
    repeat (6) @(negedge clk);
    chk("R7 result hold", int'(result), int'(r_hold));
    chk("R7 any hold", int'(any_f), int'(a_hold));

    // R8: start during a busy reduction is ignored
    run(0, 8, 8'hFF, 91, 1);
    run(2, 7, 8'h5A, 92, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule